// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Shared Interrupt

This block is a bank of sixteen general-purpose pins that software reaches through a simple word-wide register bus. Each pin has a drive level, a drive enable and an interrupt enable. Pin inputs pass through a two-stage synchronizer. The synchronized levels can be read back, and they also feed the interrupt logic.

A write to the output register carries its own per-pin write mask in the upper half of the word. Software can therefore change any subset of pins in one access, without a read-modify-write sequence. The lower eight pins each drive their own active-high interrupt line. The upper eight pins are each qualified by an enable bit and then merged into one active-high shared request.

A control register holds a clock-enable bit and a block-reset bit. Together they let software park the bank in a low-power state or clear it while the clock keeps running. Reads are registered and answer one cycle after the request, with a valid strobe.

Top module: `gpb_bank`

## Requirements
- R1: After `rst_n` is released, the control register reads 2 (block reset set, clock stopped), the output, direction and interrupt-enable registers read zero, `pin_out` and `pin_oe` are zero and `irq_shared` is low.
- R2: A write to the output register (word offset 2) updates pin n to `wdata[n]` only where `wdata[16+n]` is one; pins whose mask bit is zero keep their level. The result appears on `pin_out` on the clock edge that accepts the write.
- R3: The direction register (offset 1) stores `wdata[15:0]`; a one in bit n drives `pin_oe[n]` high (output), a zero makes the pin an input.
- R4: The pin-state register (offset 3) reads the synchronized pin levels in bits 15:0. A change on `pin_in` becomes visible two clock edges later, as long as the clock-enable bit is set.
- R5: `irq_shared` is high exactly when some pin n in 8..15 has a synchronized level of one and interrupt-enable bit n (register at offset 4) set, and the clock-enable bit is set.
- R6: `irq_direct[n]` for n in 0..7 follows the synchronized level of pin n, whatever the interrupt-enable register holds.
- R7: While control bit 1 (block reset) is set, the output, direction and interrupt-enable registers are held at zero and writes to them are ignored; clearing the bit does not restore earlier values.
- R8: While control bit 0 (clock enable) is clear, the pin-state register and `irq_direct` stay frozen at their last values and `irq_shared` is low; setting the bit again resumes sampling.
- R9: The control register (offset 0) stores `wdata[1:0]` and reads it back: 3 means reset with clock running, 1 means normal operation, 2 means reset with clock stopped.
- R10: Reads of offsets 5 to 7 return zero, and a write to the pin-state offset changes no register or pin.
- R11: A read request answers on the next cycle, with `bus_rvalid` high for exactly one cycle per request and `bus_rdata` holding the addressed register value from the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | One for write, zero for read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data; upper half is the output write mask |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_in | input | 16 | Raw pin levels from the pads |
| pin_out | output | 16 | Drive level per pin |
| pin_oe | output | 16 | Drive enable per pin |
| irq_direct | output | 8 | Individual interrupts of pins 0..7 |
| irq_shared | output | 1 | Combined, enabled interrupt of pins 8..15 |

## Verification
A corrupted output or direction bit appears on `pin_out` or `pin_oe` on the cycle after the faulty write. A wrong mask decode shows up as a pin that should have kept its level but moved. A synchronizer that samples while the clock is gated off shows up as a pin-state read that differs from the frozen value. A missing or extra stage shows up as a changed `irq_direct` sampled one cycle early or late. A register that escapes the block-reset hold shows up in the readback at once, and its interrupt-enable bits would raise `irq_shared` as soon as a high level appears on an upper pin.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the GPIO bank: register offsets and control reset value.
package gpb_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTL = 3'd0,
        REG_DIR = 3'd1,
        REG_OUT = 3'd2,
        REG_PIN = 3'd3,
        REG_IEN = 3'd4
    } gpb_reg_e;

    // Bit 1 = block reset, bit 0 = clock enable; comes up parked.
    localparam logic [1:0] CTL_RESET_VAL = 2'b10;
endpackage

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
// Multi-stage input synchronizer with an advance enable.
// Assumes: STAGES >= 2; while adv is low every stage holds its value.
module gpb_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the chain by one stage whenever sampling is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else if (adv) begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
`timescale 1ns/1ps
// Register file of the GPIO bank: control, direction, masked output,
// interrupt enable and a registered read port.
// Assumes: one access per cycle; bus_wdata upper half is the output mask.
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int DATA_W = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NPINS-1:0]  pin_state,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              ctl_clk_en,
    output logic              ctl_rst,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  ien_q
);
    logic [1:0]        ctl_q;
    logic              wr_hit;
    logic              rd_hit;
    logic [NPINS-1:0]  wmask;
    logic [NPINS-1:0]  wval;
    logic [DATA_W-1:0] rd_next;

    assign wr_hit     = bus_sel && bus_wr;
    assign rd_hit     = bus_sel && !bus_wr;
    assign wmask      = bus_wdata[DATA_W-1:NPINS];
    assign wval       = bus_wdata[NPINS-1:0];
    assign ctl_clk_en = ctl_q[0];
    assign ctl_rst    = ctl_q[1];

    // Control register: always writable, even while the block is in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl_q <= CTL_RESET_VAL;
        else if (wr_hit && bus_addr == REG_CTL)  ctl_q <= bus_wdata[1:0];
    end

    // Pin registers: cleared and locked while block reset is set.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_rst) begin
            out_q <= '0;
            dir_q <= '0;
            ien_q <= '0;
        end else if (wr_hit) begin
            if (bus_addr == REG_OUT) out_q <= (out_q & ~wmask) | (wval & wmask);
            if (bus_addr == REG_DIR) dir_q <= wval;
            if (bus_addr == REG_IEN) ien_q <= wval;
        end
    end

    // Read mux: unmapped offsets return zero.
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            REG_CTL: rd_next[1:0]       = ctl_q;
            REG_DIR: rd_next[NPINS-1:0] = dir_q;
            REG_OUT: rd_next[NPINS-1:0] = out_q;
            REG_PIN: rd_next[NPINS-1:0] = pin_state;
            REG_IEN: rd_next[NPINS-1:0] = ien_q;
            default: rd_next            = '0;
        endcase
    end

    // Registered read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_hit;
            if (rd_hit) bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/gpb_irq.sv
`timescale 1ns/1ps
// Interrupt combine: lower pins pass straight through, upper pins are
// masked by their enables and OR-reduced into one shared request.
// Assumes: inputs are already synchronized; purely combinational.
module gpb_irq #(
    parameter int NPINS     = 16,
    parameter int SHARED_LO = 8,
    localparam int NSHARED  = NPINS - SHARED_LO
) (
    input  logic [NPINS-1:0]   pin_state,
    input  logic [NSHARED-1:0] ien_hi,
    input  logic               clk_en,
    output logic [SHARED_LO-1:0] irq_direct,
    output logic               irq_shared
);
    logic [NSHARED-1:0] qual;

    // One AND gate per shared pin.
    for (genvar g = 0; g < NSHARED; g++) begin : g_qual
        assign qual[g] = pin_state[SHARED_LO + g] & ien_hi[g];
    end

    assign irq_direct = pin_state[SHARED_LO-1:0];
    assign irq_shared = clk_en & (|qual);
endmodule

// File: rtl/gpb_bank.sv
`timescale 1ns/1ps
// Top of the 16-pin GPIO bank: register file, gated input synchronizer
// and interrupt combine. Assumes a single clock domain on the bus side.
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SHARED_LO   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = 2 * NPINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [SHARED_LO-1:0] irq_direct,
    output logic                 irq_shared
);
    logic             ctl_clk_en;
    logic             ctl_rst;
    logic [NPINS-1:0] pin_state;
    logic [NPINS-1:0] ien_q;

    gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ctl_clk_en),
        .d     (pin_in),
        .q     (pin_state)
    );

    gpb_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pin_state  (pin_state),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .ctl_clk_en (ctl_clk_en),
        .ctl_rst    (ctl_rst),
        .out_q      (pin_out),
        .dir_q      (pin_oe),
        .ien_q      (ien_q)
    );

    gpb_irq #(.NPINS(NPINS), .SHARED_LO(SHARED_LO)) u_irq (
        .pin_state  (pin_state),
        .ien_hi     (ien_q[NPINS-1:SHARED_LO]),
        .clk_en     (ctl_clk_en),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );
endmodule

// File: rtl/gpb_bank_chk.sv
`timescale 1ns/1ps
// Property checker for gpb_bank, attached through bind below.
module gpb_bank_chk
    import gpb_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter int SHARED_LO = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [2*NPINS-1:0]    bus_wdata,
    input logic                  bus_rvalid,
    input logic                  ctl_clk_en,
    input logic                  ctl_rst,
    input logic [NPINS-1:0]      ien_q,
    input logic [NPINS-1:0]      pin_state,
    input logic [NPINS-1:0]      pin_out,
    input logic [NPINS-1:0]      pin_oe,
    input logic                  irq_shared
);
    // R2
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_OUT && !ctl_rst) |=>
        (((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[2*NPINS-1:NPINS])) == '0));

    // R3
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DIR && !ctl_rst) |=>
        (pin_oe == $past(bus_wdata[NPINS-1:0])));

    // R5
    shared_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared |-> (ien_q[NPINS-1:SHARED_LO] != '0));

    // R7
    blk_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rst && $past(ctl_rst)) |-> (pin_out == '0 && pin_oe == '0 && ien_q == '0));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_clk_en) |-> $stable(pin_state));

    // R8
    shared_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_clk_en |-> !irq_shared);

    // R11
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
endmodule

bind gpb_bank gpb_bank_chk #(.NPINS(NPINS), .SHARED_LO(SHARED_LO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .ctl_clk_en (ctl_clk_en),
    .ctl_rst    (ctl_rst),
    .ien_q      (ien_q),
    .pin_state  (pin_state),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq_shared (irq_shared)
);

// File: tb/test_gpb_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor pops them
// when the design presents read data; port levels are checked directly.
module test_gpb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [7:0]  irq_direct;
    logic        irq_shared;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    gpb_bank i_gpb_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_direct(irq_direct), .irq_shared(irq_shared)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each read response with the oldest expectation (R11).
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 actual=%h expected=no response", bus_rdata);
            end else begin
                string t;
                logic [31:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 irq_shared", {31'h0, irq_shared}, 32'h0);
        rd(3'd0, 32'h2, "R1 ctl");
        rd(3'd2, 32'h0, "R1 out");
        rd(3'd1, 32'h0, "R1 dir");
        rd(3'd4, 32'h0, "R1 ien");

        // R9 control encodings
        wr(3'd0, 32'h3); rd(3'd0, 32'h3, "R9 ctl=3");
        wr(3'd0, 32'h1); rd(3'd0, 32'h1, "R9 ctl=1");

        // R2 masked output writes
        wr(3'd2, 32'hFFFF_A5A5);
        check("R2 full mask", {16'h0, pin_out}, 32'hA5A5);
        wr(3'd2, 32'h00F0_0F0F);
        check("R2 partial mask", {16'h0, pin_out}, 32'hA505);
        wr(3'd2, 32'h0000_FFFF);
        check("R2 empty mask", {16'h0, pin_out}, 32'hA505);
        rd(3'd2, 32'hA505, "R2 readback");

        // R3 direction
        wr(3'd1, 32'hFFFF_1234);
        check("R3 pin_oe", {16'h0, pin_oe}, 32'h1234);
        rd(3'd1, 32'h1234, "R3 readback");

        // R4 / R6 synchronizer latency and direct interrupts
        pin_in = 16'hBEEF;
        @(negedge clk);
        check("R4 one edge", {24'h0, irq_direct}, 32'h0);
        @(negedge clk);
        check("R4 two edges", {24'h0, irq_direct}, 32'hEF);
        rd(3'd3, 32'hBEEF, "R4 pin state");

        // R5 shared interrupt combine
        check("R5 no enables", {31'h0, irq_shared}, 32'h0);
        wr(3'd4, 32'h0000_0100);
        check("R5 enabled low pin", {31'h0, irq_shared}, 32'h0);
        wr(3'd4, 32'h0000_0200);
        check("R5 enabled high pin", {31'h0, irq_shared}, 32'h1);
        wr(3'd4, 32'h0000_00FF);
        check("R5 low enables only", {31'h0, irq_shared}, 32'h0);
        check("R6 direct ungated", {24'h0, irq_direct}, 32'hEF);
        wr(3'd4, 32'h0000_0000);
        check("R6 direct with no enables", {24'h0, irq_direct}, 32'hEF);
        wr(3'd4, 32'h0000_0200);
        pin_in = 16'h00EF;
        idle(2);
        check("R5 source dropped", {31'h0, irq_shared}, 32'h0);
        pin_in = 16'hBEEF;
        idle(2);
        check("R5 source back", {31'h0, irq_shared}, 32'h1);

        // R8 clock gating freezes sampling and masks shared request
        wr(3'd0, 32'h0);
        check("R8 shared forced low", {31'h0, irq_shared}, 32'h0);
        pin_in = 16'h0000;
        idle(4);
        rd(3'd3, 32'hBEEF, "R8 frozen state");
        check("R8 frozen direct", {24'h0, irq_direct}, 32'hEF);
        wr(3'd0, 32'h1);
        idle(3);
        rd(3'd3, 32'h0000, "R8 resumed");

        // R7 block reset holds and locks registers
        wr(3'd2, 32'hFFFF_5A5A);
        wr(3'd1, 32'h0000_00FF);
        wr(3'd4, 32'h0000_FF00);
        wr(3'd0, 32'h3);
        idle(1);
        check("R7 pin_out cleared", {16'h0, pin_out}, 32'h0);
        check("R7 pin_oe cleared", {16'h0, pin_oe}, 32'h0);
        rd(3'd4, 32'h0, "R7 ien cleared");
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_FFFF);
        idle(1);
        check("R7 write ignored out", {16'h0, pin_out}, 32'h0);
        check("R7 write ignored dir", {16'h0, pin_oe}, 32'h0);
        wr(3'd0, 32'h1);
        rd(3'd2, 32'h0, "R7 no restore");

        // R10 unmapped offsets and read-only pin state
        rd(3'd5, 32'h0, "R10 offset 5");
        rd(3'd7, 32'h0, "R10 offset 7");
        wr(3'd2, 32'hFFFF_00C3);
        wr(3'd3, 32'hFFFF_FFFF);
        check("R10 pin_out untouched", {16'h0, pin_out}, 32'h00C3);
        rd(3'd3, 32'h0000, "R10 pin state untouched");
        rd(3'd1, 32'h0, "R10 dir untouched");

        // R9 low-power encoding
        wr(3'd0, 32'h2);
        rd(3'd0, 32'h2, "R9 ctl=2");

        idle(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 actual=%0d pending expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule